// File: doc/BRIEF.md
# Serial Dongle Register Access Master

This engine drives a two-wire clocked serial link to an external infrared transceiver dongle, so that software no longer toggles the line bit by bit. The host places one request: a line reset, an indexed register write or an indexed register read. The engine then produces the whole clock and data waveform by itself. It raises `busy` while it works, gives a one-cycle `done` when it finishes, and after a read it returns the captured byte together with a flag that tells whether the dongle answered.

All line activity is built from one kind of clock pulse. The clock is low for two delay units while the data line carries the value of the pulse, and then high for one unit. A delay unit is `unit_len` system cycles, taken from the request. Reads wait for the dongle on a separate active-low valid line, and the number of pulses spent waiting is bounded. When the dongle does not answer, the engine leaves through a short dummy exit. Both line inputs pass through a synchroniser. They are sampled at the falling clock edge that closes a pulse.

Top module: `dngl_master`

## Requirements
- R1: Reset state: after reset, `busy`, `done`, `line_clk`, `line_dout`, `rd_data` and `rd_valid_seen` are all 0. While `busy` is low, `line_clk` stays low and `line_dout` stays low.
- R2: A request is accepted on a clock edge where `req` is 1 and `busy` is 0, with `op` equal to 0 (line reset), 1 (write) or 2 (read). `busy` is 1 from the next cycle until the done cycle. A request with `op` = 3, or any request made while `busy` is 1, has no effect.
- R3: Every pulse is 2·U cycles with `line_clk` low and `line_dout` holding the pulse value, then U cycles with `line_clk` high. U is `unit_len` (0 counts as 1), captured at acceptance. The first pulse begins in the cycle after the accepting edge.
- R4: The command byte has bits 7:1 equal to `dev_addr | reg_idx` and bit 0 equal to 1 for a write and 0 for a read. Every byte is sent least significant bit first, one bit per pulse.
- R5: A write or a read begins with one pulse whose data is 0, placed ahead of the command byte.
- R6: A write sends its pulses in this order: the leading pulse, the command byte, then `wr_data`, then 2 pulses with data 0.
- R7: After the read command byte, the engine gives up to 10 pulses with data 0. `line_vld_n` is sampled at the end of each of these pulses, and polling stops after the first pulse at which it reads 0. `line_vld_n` is not sampled in any other pulse.
- R8: When valid was seen, 8 pulses with data 0 follow. `line_din` is sampled at the end of each of them and stored least significant bit first. The read then returns that byte with `rd_valid_seen` = 1.
- R9: When valid was not seen within the 10 pulses, only 2 pulses with data 0 follow, and the read returns `rd_data` = 0 with `rd_valid_seen` = 0.
- R10: Every read ends with 1 pulse with data 1, followed by 3 pulses with data 0.
- R11: A line reset (`op` = 0) issues 30 pulses with data 0 and nothing else.
- R12: In the cycle after the last high phase, `done` is 1 for exactly one cycle, `busy` is 0, and `line_clk` and `line_dout` are 0. `rd_data` and `rd_valid_seen` change only in a done cycle that ends a read. After a write or a line reset they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe |
| op | input | 2 | 0 line reset, 1 write, 2 read, 3 none |
| dev_addr | input | 7 | Device address field of the command byte |
| reg_idx | input | 7 | Register index, ORed into the command byte |
| wr_data | input | 8 | Byte sent by a write |
| unit_len | input | LEN_W | Cycles per delay unit (0 acts as 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid_seen | output | 1 | Last read saw the dongle's valid |
| line_clk | output | 1 | Serial clock to the dongle |
| line_dout | output | 1 | Serial data to the dongle |
| line_din | input | 1 | Serial data from the dongle |
| line_vld_n | input | 1 | Active-low read-valid from the dongle |

## Verification
The hardest situations to reach are the edges of the valid poll. These are valid arriving on the very first poll pulse, valid arriving on the tenth and last poll pulse, and valid never arriving. In each case the engine must pick the right tail and the right pulse count. The bench acts as the dongle. It places the valid assertion on a chosen poll pulse and presents each read bit at the start of its pulse. In one read it also holds valid low through the command byte, which shows that valid is ignored outside the poll. The bench then compares its own expected waveform with the line outputs on every cycle. A request made in the middle of a line reset and an idle request with code 3 check that such requests are ignored.

// File: rtl/dngl_pkg.sv
package dngl_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH
    } st_e;

    typedef enum logic [3:0] {
        SG_LEAD,
        SG_CMD,
        SG_WDAT,
        SG_WTAIL,
        SG_POLL,
        SG_RDAT,
        SG_DUMMY,
        SG_MARK,
        SG_ETAIL,
        SG_LRST
    } seg_e;
endpackage

// File: rtl/dngl_sync.sv
module dngl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] src_d;
        if (g == 0) begin : g_first
            assign src_d = d_in;
        end else begin : g_next
            assign src_d = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= src_d;
        end
    end

    assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/dngl_prescale.sv
module dngl_prescale #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             tick
);
    logic [LEN_W-1:0] cnt_d, cnt_q, last;

    always_comb begin
        last  = (len == '0) ? '0 : len - LEN_W'(1);
        tick  = run && (cnt_q == last);
        cnt_d = (!run || tick) ? '0 : cnt_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dngl_master.sv
module dngl_master
    import dngl_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int POLL_MAX     = 10,
    parameter int RST_PULSES   = 30,
    parameter int WR_TAIL      = 2,
    parameter int DUMMY_PULSES = 2,
    parameter int END_TAIL     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [ADDR_W-1:0] reg_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  unit_len,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid_seen,
    output logic              line_clk,
    output logic              line_dout,
    input  logic              line_din,
    input  logic              line_vld_n
);
    localparam int CNT_A   = (RST_PULSES > POLL_MAX) ? RST_PULSES : POLL_MAX;
    localparam int CNT_MAX = (CNT_A > BYTE_W) ? CNT_A : BYTE_W;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int BIDX_W  = $clog2(BYTE_W);

    typedef struct packed {
        st_e               st;
        seg_e              seg;
        op_e               opc;
        logic [CNT_W-1:0]  bcnt;
        logic              ucnt;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] wdat;
        logic [LEN_W-1:0]  len;
        logic [BYTE_W-1:0] rxsh;
        logic              seen;
        logic              busy;
        logic              done;
        logic              clk_o;
        logic              dout_o;
        logic [BYTE_W-1:0] rdat;
        logic              rvld;
    } regs_t;

    regs_t d_d, d_q;
    logic  tick;
    logic  din_s, vld_n_s;

    dngl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({line_vld_n, line_din}),
        .d_out ({vld_n_s, din_s})
    );

    dngl_prescale #(.LEN_W(LEN_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (d_q.st != ST_IDLE),
        .len   (d_q.len),
        .tick  (tick)
    );

    always_comb begin
        seg_e             nseg;
        logic [CNT_W-1:0] ncnt;
        logic             fin;
        logic [BIDX_W-1:0] nbi;
        d_d      = d_q;
        d_d.done = 1'b0;
        nseg     = d_q.seg;
        ncnt     = d_q.bcnt + CNT_W'(1);
        fin      = 1'b0;
        nbi      = '0;
        case (d_q.st)
            ST_IDLE: begin
                if (req && (op != 2'(OP_NONE))) begin
                    d_d.st     = ST_LOW;
                    d_d.opc    = op_e'(op);
                    d_d.seg    = (op == 2'(OP_RESET)) ? SG_LRST : SG_LEAD;
                    d_d.bcnt   = '0;
                    d_d.ucnt   = 1'b0;
                    d_d.cmd    = {dev_addr | reg_idx, op == 2'(OP_WRITE)};
                    d_d.wdat   = wr_data;
                    d_d.len    = unit_len;
                    d_d.rxsh   = '0;
                    d_d.seen   = 1'b0;
                    d_d.busy   = 1'b1;
                    d_d.clk_o  = 1'b0;
                    d_d.dout_o = 1'b0;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    if (d_q.ucnt) begin
                        d_d.st    = ST_HIGH;
                        d_d.clk_o = 1'b1;
                        d_d.ucnt  = 1'b0;
                    end else begin
                        d_d.ucnt = 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    case (d_q.seg)
                        SG_LEAD: begin nseg = SG_CMD; ncnt = '0; end
                        SG_CMD: if (d_q.bcnt == CNT_W'(BYTE_W-1)) begin
                            nseg = (d_q.opc == OP_WRITE) ? SG_WDAT : SG_POLL;
                            ncnt = '0;
                        end
                        SG_WDAT: if (d_q.bcnt == CNT_W'(BYTE_W-1)) begin
                            nseg = SG_WTAIL; ncnt = '0;
                        end
                        SG_WTAIL: fin = (d_q.bcnt == CNT_W'(WR_TAIL-1));
                        SG_POLL: begin
                            if (!vld_n_s) begin
                                d_d.seen = 1'b1; nseg = SG_RDAT; ncnt = '0;
                            end else if (d_q.bcnt == CNT_W'(POLL_MAX-1)) begin
                                nseg = SG_DUMMY; ncnt = '0;
                            end
                        end
                        SG_RDAT: begin
                            d_d.rxsh[d_q.bcnt[BIDX_W-1:0]] = din_s;
                            if (d_q.bcnt == CNT_W'(BYTE_W-1)) begin
                                nseg = SG_MARK; ncnt = '0;
                            end
                        end
                        SG_DUMMY: if (d_q.bcnt == CNT_W'(DUMMY_PULSES-1)) begin
                            nseg = SG_MARK; ncnt = '0;
                        end
                        SG_MARK: begin nseg = SG_ETAIL; ncnt = '0; end
                        SG_ETAIL: fin = (d_q.bcnt == CNT_W'(END_TAIL-1));
                        default:  fin = (d_q.bcnt == CNT_W'(RST_PULSES-1));
                    endcase
                    d_d.clk_o = 1'b0;
                    if (fin) begin
                        d_d.st     = ST_IDLE;
                        d_d.busy   = 1'b0;
                        d_d.done   = 1'b1;
                        d_d.dout_o = 1'b0;
                        if (d_q.opc == OP_READ) begin
                            d_d.rdat = d_q.rxsh;
                            d_d.rvld = d_q.seen;
                        end
                    end else begin
                        d_d.st   = ST_LOW;
                        d_d.seg  = nseg;
                        d_d.bcnt = ncnt;
                        nbi      = ncnt[BIDX_W-1:0];
                        case (nseg)
                            SG_CMD:  d_d.dout_o = d_q.cmd[nbi];
                            SG_WDAT: d_d.dout_o = d_q.wdat[nbi];
                            SG_MARK: d_d.dout_o = 1'b1;
                            default: d_d.dout_o = 1'b0;
                        endcase
                    end
                end
            end
            default: d_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q      <= '0;
            d_q.st   <= ST_IDLE;
            d_q.seg  <= SG_LEAD;
            d_q.opc  <= OP_NONE;
        end else begin
            d_q <= d_d;
        end
    end

    assign busy          = d_q.busy;
    assign done          = d_q.done;
    assign rd_data       = d_q.rdat;
    assign rd_valid_seen = d_q.rvld;
    assign line_clk      = d_q.clk_o;
    assign line_dout     = d_q.dout_o;
endmodule

// File: rtl/dngl_master_chk.sv
module dngl_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       busy,
    input logic       done,
    input logic [7:0] rd_data,
    input logic       rd_valid_seen,
    input logic       line_clk,
    input logic       line_dout
);
    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_clk && !line_dout)); // R1

    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req)); // R2

    AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clk && $past(line_clk)) |-> $stable(line_dout)); // R3

    AST_NOVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_seen |-> (rd_data == 8'h00)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R12

    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_data) || !$stable(rd_valid_seen)) |-> done); // R12
endmodule

bind dngl_master dngl_master_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (req),
    .busy          (busy),
    .done          (done),
    .rd_data       (rd_data),
    .rd_valid_seen (rd_valid_seen),
    .line_clk      (line_clk),
    .line_dout     (line_dout)
);

// File: tb/tb_dngl_master.sv
module tb_dngl_master;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] op = 2'd3;
    logic [6:0] dev_addr = '0;
    logic [6:0] reg_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] unit_len = 8'd2;
    logic       busy, done, rd_valid_seen, line_clk, line_dout;
    logic [7:0] rd_data;
    logic       line_din = 1'b0;
    logic       line_vld_n = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cur_rd = 0;
    int cur_vs = 0;

    int    e_clk[$], e_dout[$], e_din[$], e_vld[$];
    string e_tag[$];

    dngl_master dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op),
        .dev_addr(dev_addr), .reg_idx(reg_idx), .wr_data(wr_data),
        .unit_len(unit_len), .busy(busy), .done(done), .rd_data(rd_data),
        .rd_valid_seen(rd_valid_seen), .line_clk(line_clk),
        .line_dout(line_dout), .line_din(line_din), .line_vld_n(line_vld_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void add_pulse(int d, int din, int vld, string tag, int u);
        for (int i = 0; i < 3*u; i++) begin
            e_clk.push_back((i >= 2*u) ? 1 : 0);
            e_dout.push_back(d);
            e_din.push_back(din);
            e_vld.push_back(vld);
            e_tag.push_back(tag);
        end
    endfunction

    task automatic check_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, tag, "busy/done idle", {busy, done}, 0);
            chk(line_clk == 1'b0 && line_dout == 1'b0, tag, "line idle", {line_clk, line_dout}, 0);
        end
    endtask

    // kval: poll pulse (1..10) at which valid goes low, 0 = never
    task automatic run_op(input int opc, input int addr, input int idx, input int wd,
                          input int len, input int kval, input int rxb,
                          input bit early, input bit poke);
        int u, cmd, seen, n;
        u = (len == 0) ? 1 : len;
        e_clk.delete(); e_dout.delete(); e_din.delete(); e_vld.delete(); e_tag.delete();
        seen = 0;
        if (opc == 0) begin
            for (int i = 0; i < 30; i++) add_pulse(0, 1, 1, "R11", u);
        end else begin
            add_pulse(0, 1, early ? 0 : 1, "R5", u);
            cmd = (((addr | idx) & 8'h7f) << 1) | ((opc == 1) ? 1 : 0);
            for (int i = 0; i < 8; i++) add_pulse((cmd >> i) & 1, 1, early ? 0 : 1, "R4", u);
            if (opc == 1) begin
                for (int i = 0; i < 8; i++) add_pulse((wd >> i) & 1, 1, 1, "R6", u);
                for (int i = 0; i < 2; i++) add_pulse(0, 1, 1, "R6", u);
            end else begin
                for (int j = 1; j <= 10; j++) begin
                    int v;
                    v = (kval > 0 && j >= kval) ? 0 : 1;
                    add_pulse(0, ~(rxb >> (j % 8)) & 1, v, "R7", u);
                    if (v == 0) begin seen = 1; break; end
                end
                if (seen != 0) begin
                    for (int i = 0; i < 8; i++) add_pulse(0, (rxb >> i) & 1, 0, "R8", u);
                end else begin
                    for (int i = 0; i < 2; i++) add_pulse(0, 1, 1, "R9", u);
                end
                add_pulse(1, 0, 1, "R10", u);
                for (int i = 0; i < 3; i++) add_pulse(0, 1, 1, "R10", u);
                cur_rd = (seen != 0) ? rxb : 0;
                cur_vs = seen;
            end
        end
        @(negedge clk);
        req = 1'b1; op = 2'(opc); dev_addr = 7'(addr); reg_idx = 7'(idx);
        wr_data = 8'(wd); unit_len = 8'(len);
        @(negedge clk);
        req = 1'b0; op = 2'd3;
        unit_len = 8'd7; // later changes must not affect a running transfer (R3)
        n = e_clk.size();
        for (int i = 0; i < n; i++) begin
            chk(busy == 1'b1 && done == 1'b0, "R2", "busy during transfer", {busy, done}, 2);
            chk(line_clk == 1'(e_clk[i]), "R3", "line_clk", line_clk, e_clk[i]);
            chk(line_dout == 1'(e_dout[i]), e_tag[i], "line_dout", line_dout, e_dout[i]);
            line_din   = 1'(e_din[i]);
            line_vld_n = 1'(e_vld[i]);
            if (poke && i == 5) begin req = 1'b1; op = 2'd2; end
            if (poke && i == 7) begin req = 1'b0; op = 2'd3; end
            @(negedge clk);
        end
        line_vld_n = 1'b1;
        chk(done == 1'b1 && busy == 1'b0, "R12", "done cycle", {done, busy}, 2);
        chk(line_clk == 1'b0 && line_dout == 1'b0, "R12", "line low at done",
            {line_clk, line_dout}, 0);
        chk(rd_data == 8'(cur_rd), (opc == 2) ? ((seen != 0) ? "R8" : "R9") : "R12",
            "rd_data", rd_data, cur_rd);
        chk(rd_valid_seen == 1'(cur_vs), (opc == 2) ? ((seen != 0) ? "R8" : "R9") : "R12",
            "rd_valid_seen", rd_valid_seen, cur_vs);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R12", "done lasts one cycle", {done, busy}, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
        chk(line_clk == 0 && line_dout == 0, "R1", "line after reset", {line_clk, line_dout}, 0);
        chk(rd_data == 0 && rd_valid_seen == 0, "R1", "result after reset",
            {rd_valid_seen, rd_data}, 0);
        // op code 3 is ignored (R2)
        req = 1'b1; op = 2'd3;
        @(negedge clk);
        req = 1'b0;
        check_idle(4, "R2");
        run_op(2, 7'h20, 7'h01, 0, 2, 3, 8'h96, 1'b0, 1'b0);   // read, valid on pulse 3
        run_op(1, 7'h20, 7'h05, 8'hA5, 2, 0, 0, 1'b0, 1'b0);   // write keeps result (R12)
        run_op(1, 7'h11, 7'h42, 8'h3C, 0, 0, 0, 1'b0, 1'b0);   // unit 0 acts as 1 (R3)
        run_op(2, 7'h40, 7'h02, 0, 2, 0, 8'hFF, 1'b0, 1'b0);   // no valid: timeout (R9)
        run_op(2, 7'h05, 7'h10, 0, 3, 1, 8'h5A, 1'b1, 1'b0);   // valid early, first poll (R7)
        run_op(2, 7'h7F, 7'h00, 0, 1, 10, 8'hC3, 1'b0, 1'b0);  // valid on last poll (R7)
        run_op(0, 0, 0, 0, 2, 0, 0, 1'b0, 1'b1);               // line reset, poke while busy (R11, R2)
        check_idle(3, "R2");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule